// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block gathers a workstation's small housekeeping registers behind one synchronous register bus. A bus master picks a register with a 3-bit select code and, for the two wide registers, a byte offset inside the register's window. Writes take effect at the clock edge where the write strobe is high. Reads are combinational: read data is valid in the same cycle as the read strobe, zero-extended to the bus width. The byte registers ignore the offset.

Several registers have write side effects. One bit of the first auxiliary register fires a one-cycle terminal-count pulse toward a floppy controller and is never stored. The second auxiliary register carries a power-fail flag. The flag is set or cleared whenever the power-failing input changes level, but it is only set when the power-interrupt enable is on. Software clears the flag by writing one to a clear bit. The second auxiliary register also holds a power-off bit that raises a one-cycle power-off request. Writing the request bit of the system control register raises a one-cycle system reset request and leaves a reset-status value behind.

The block reset clears only part of the state. The diagnostic byte, the LED word and the system control word keep their values through a reset, so software can see afterwards that the reset it requested took place.

Top module: `aux_ctl_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the configuration, modem-control, aux1 and aux2 registers read as zero, and `irq`, `fdc_tc`, `pwr_off_req` and `sys_rst_req` are low.
- R2: A block reset leaves the diagnostic register and the system control register unchanged, so a system control value of 0x00000002 is still read back after the reset.
- R3: Select codes 0 (configuration), 1 (diagnostic) and 2 (modem control) are plain 8-bit storage and read back exactly what was last written, zero-extended. Select code 7 always reads zero. The read data is zero whenever `bus_rd` is low.
- R4: A write to aux1 (select 5) stores the written byte with bit 1 forced to zero. When bit 1 of the write data is one, `fdc_tc` is high for exactly the one cycle that follows the write edge. Otherwise it stays low.
- R5: A write to aux2 (select 6) takes only bit 0 (power off) and bit 1 (flag clear) from the data and keeps the current power-fail flag in bit 5. When bit 1 is one, the flag is cleared. Bit 1 is never stored, and bit 0 is stored as written.
- R6: A write to aux2 with bit 0 set drives `pwr_off_req` high for exactly the one cycle after the write edge.
- R7: At each clock edge where `pwr_fail` differs from its value at the previous edge, the power-fail flag becomes `pwr_fail` AND configuration bit 3, using the stored configuration. While `pwr_fail` holds its level, the flag only changes through an aux2 clear.
- R8: `irq` is registered. Its value equals (power-fail flag AND configuration bit 3) as it stood one clock earlier, so a change of either is seen on `irq` one cycle after the register changes.
- R9: A write to system control (select 4) at offset 0 with bit 0 set loads 0x00000002 and drives `sys_rst_req` high for one cycle. A write with bit 0 clear, or at a nonzero offset, changes nothing and raises no request.
- R10: System control reads at offset 0 return the stored word. Reads at offsets 1 to 3 return zero.
- R11: The 16-bit LED register (select 3) is written and read only at offset 0. Writes at other offsets are ignored, and reads there return zero.
- R12: When an aux2 clear write and a power-fail input change fall on the same edge, the input change decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 3 | Register select code |
| bus_off | input | OFF_W | Byte offset inside the selected register's window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| pwr_fail | input | 1 | Power-failing indication, level |
| irq | output | 1 | Power-fail interrupt, level |
| fdc_tc | output | 1 | Floppy terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The hardest case to reach from the ports is an aux2 clear write landing on the same edge as a power-fail level change. The stimulus raises `pwr_fail` at the same falling edge where it presents the clear write, then reads aux2 back and expects the flag still set. The other delicate case is a flag that is set while the interrupt is masked. The bench sets the flag with the enable on, clears the enable, and checks that the flag stays readable in aux2 while `irq` falls one cycle after the configuration write. It then sets the enable again and watches `irq` return with the same lag.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_DIAG  = 3'd1,
    SEL_MODEM = 3'd2,
    SEL_LED   = 3'd3,
    SEL_SYS   = 3'd4,
    SEL_AUX1  = 3'd5,
    SEL_AUX2  = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  localparam int BYTE_W        = 8;
  localparam int CFG_PFIE_BIT  = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_FLAG_BIT = 5;
  localparam int SYS_REQ_BIT   = 0;
  localparam int SYS_STAT_BIT  = 1;

endpackage

// File: rtl/aux_ctl_misc.sv
module aux_ctl_misc
  import aux_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_diag,
  input  logic              wr_modem,
  input  logic              wr_aux1,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] diag_q,
  output logic [BYTE_W-1:0] modem_q,
  output logic [BYTE_W-1:0] aux1_q,
  output logic              fdc_tc
);

  logic [BYTE_W-1:0] aux1_d;
  logic              tc_d;

  // aux1 stores the written byte without the pulse bit
  always_comb begin
    aux1_d              = wdata;
    aux1_d[AUX1_TC_BIT] = 1'b0;
    tc_d                = wr_aux1 & wdata[AUX1_TC_BIT];
  end

  // registers cleared by the block reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      modem_q <= '0;
      aux1_q  <= '0;
      fdc_tc  <= 1'b0;
    end else begin
      if (wr_cfg)   cfg_q   <= wdata;
      if (wr_modem) modem_q <= wdata;
      if (wr_aux1)  aux1_q  <= aux1_d;
      fdc_tc <= tc_d;
    end
  end

  // diagnostic byte survives the block reset
  always_ff @(posedge clk) begin
    if (wr_diag) diag_q <= wdata;
  end

  AST_TC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_tc |-> $past(wr_aux1 && wdata[AUX1_TC_BIT])); // R4
  AST_AUX1_TC_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_aux1) |-> !aux1_q[AUX1_TC_BIT]); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_cfg) |-> $stable(cfg_q)); // R3

endmodule

// File: rtl/aux_ctl_pwr.sv
module aux_ctl_pwr
  import aux_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_aux2,
  input  logic              wr_off,
  input  logic              wr_clr,
  input  logic              pwr_fail,
  input  logic              cfg_pfie,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              irq,
  output logic              pwr_off_req
);

  logic off_q, off_d;
  logic flag_q, flag_d;
  logic pf_prev_q;
  logic pf_evt;
  logic irq_d;
  logic poff_d;

  always_comb begin
    pf_evt = pwr_fail ^ pf_prev_q;
    off_d  = off_q;
    flag_d = flag_q;
    if (wr_aux2) begin
      off_d = wr_off;
      if (wr_clr) flag_d = 1'b0;
    end
    // an input level change decides the flag, even over a clear
    if (pf_evt) flag_d = pwr_fail & cfg_pfie;
    irq_d  = flag_q & cfg_pfie;
    poff_d = wr_aux2 & wr_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q       <= 1'b0;
      flag_q      <= 1'b0;
      pf_prev_q   <= 1'b0;
      irq         <= 1'b0;
      pwr_off_req <= 1'b0;
    end else begin
      off_q       <= off_d;
      flag_q      <= flag_d;
      pf_prev_q   <= pwr_fail;
      irq         <= irq_d;
      pwr_off_req <= poff_d;
    end
  end

  always_comb begin
    aux2_q                = '0;
    aux2_q[AUX2_OFF_BIT]  = off_q;
    aux2_q[AUX2_FLAG_BIT] = flag_q;
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(flag_q && cfg_pfie)); // R8
  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pwr_fail && cfg_pfie)); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_aux2 && wr_clr) && !$past(pf_evt)) |-> !flag_q); // R5
  AST_PWROFF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> $past(wr_aux2 && wr_off)); // R6

endmodule

// File: rtl/aux_ctl_wide.sv
module aux_ctl_wide
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_led,
  input  logic              wr_sys,
  input  logic [OFF_W-1:0]  off,
  input  logic [LED_W-1:0]  wdata_lo,
  output logic [LED_W-1:0]  led_q,
  output logic [DATA_W-1:0] sys_q,
  output logic              sys_rst_req
);

  localparam logic [DATA_W-1:0] SYS_AFTER_REQ =
    {{(DATA_W-1){1'b0}}, 1'b1} << SYS_STAT_BIT;

  logic off_zero;
  logic led_we;
  logic sys_we;

  always_comb begin
    off_zero = (off == '0);
    led_we   = wr_led & off_zero;
    sys_we   = wr_sys & off_zero & wdata_lo[SYS_REQ_BIT];
  end

  // LED and system control words survive the block reset
  always_ff @(posedge clk) begin
    if (led_we) led_q <= wdata_lo;
    if (sys_we) sys_q <= SYS_AFTER_REQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= sys_we;
  end

  AST_REQ_LEAVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (sys_q == SYS_AFTER_REQ)); // R9
  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_sys && off_zero && wdata_lo[SYS_REQ_BIT])); // R9
  AST_LED_OFFSET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_led && !off_zero) |-> $stable(led_q)); // R11

endmodule

// File: rtl/aux_ctl_top.sv
module aux_ctl_top
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_sel,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail,
  output logic              irq,
  output logic              fdc_tc,
  output logic              pwr_off_req,
  output logic              sys_rst_req
);

  sel_e              sel;
  logic              wr_cfg, wr_diag, wr_modem, wr_led, wr_sys, wr_aux1, wr_aux2;
  logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux1_q, aux2_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic              off_zero;

  always_comb begin
    sel      = sel_e'(bus_sel);
    wr_cfg   = bus_wr & (sel == SEL_CFG);
    wr_diag  = bus_wr & (sel == SEL_DIAG);
    wr_modem = bus_wr & (sel == SEL_MODEM);
    wr_led   = bus_wr & (sel == SEL_LED);
    wr_sys   = bus_wr & (sel == SEL_SYS);
    wr_aux1  = bus_wr & (sel == SEL_AUX1);
    wr_aux2  = bus_wr & (sel == SEL_AUX2);
    off_zero = (bus_off == '0);
  end

  generate
    if (LED_W < DATA_W) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LED_W];
    end
  endgenerate

  aux_ctl_misc u_misc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cfg   (wr_cfg),
    .wr_diag  (wr_diag),
    .wr_modem (wr_modem),
    .wr_aux1  (wr_aux1),
    .wdata    (bus_wdata[BYTE_W-1:0]),
    .cfg_q    (cfg_q),
    .diag_q   (diag_q),
    .modem_q  (modem_q),
    .aux1_q   (aux1_q),
    .fdc_tc   (fdc_tc)
  );

  aux_ctl_pwr u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_aux2     (wr_aux2),
    .wr_off      (bus_wdata[AUX2_OFF_BIT]),
    .wr_clr      (bus_wdata[AUX2_CLR_BIT]),
    .pwr_fail    (pwr_fail),
    .cfg_pfie    (cfg_q[CFG_PFIE_BIT]),
    .aux2_q      (aux2_q),
    .irq         (irq),
    .pwr_off_req (pwr_off_req)
  );

  aux_ctl_wide #(
    .DATA_W (DATA_W),
    .LED_W  (LED_W),
    .OFF_W  (OFF_W)
  ) u_wide (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_led      (wr_led),
    .wr_sys      (wr_sys),
    .off         (bus_off),
    .wdata_lo    (bus_wdata[LED_W-1:0]),
    .led_q       (led_q),
    .sys_q       (sys_q),
    .sys_rst_req (sys_rst_req)
  );

  // combinational read, zero-extended, zero when idle
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_CFG:   bus_rdata = DATA_W'(cfg_q);
        SEL_DIAG:  bus_rdata = DATA_W'(diag_q);
        SEL_MODEM: bus_rdata = DATA_W'(modem_q);
        SEL_LED:   bus_rdata = off_zero ? DATA_W'(led_q) : '0;
        SEL_SYS:   bus_rdata = off_zero ? sys_q : '0;
        SEL_AUX1:  bus_rdata = DATA_W'(aux1_q);
        SEL_AUX2:  bus_rdata = DATA_W'(aux2_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R3
  AST_PULSES_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fdc_tc, pwr_off_req, sys_rst_req})); // R4

endmodule

// File: tb/test_aux_ctl_top.sv
module test_aux_ctl_top;

  localparam int DATA_W = 32;
  localparam int LED_W  = 16;
  localparam int OFF_W  = 2;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [2:0]        bus_sel;
  logic [OFF_W-1:0]  bus_off;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              pwr_fail;
  logic              irq;
  logic              fdc_tc;
  logic              pwr_off_req;
  logic              sys_rst_req;

  int errs;
  int checks;
  bit done;

  aux_ctl_top #(.DATA_W(DATA_W), .LED_W(LED_W), .OFF_W(OFF_W)) i_aux_ctl_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwr_fail(pwr_fail), .irq(irq), .fdc_tc(fdc_tc),
    .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_off = o; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] o, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = s; bus_off = o;
    #1;
    chk(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] aux2_exp(input bit flag, input bit off);
    return (flag ? 32'h20 : 32'h0) | (off ? 32'h1 : 32'h0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    errs = 0; checks = 0; done = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = '0; bus_off = '0;
    bus_wdata = '0; pwr_fail = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 fdc_tc in reset", 32'(fdc_tc), 0);
    chk("R1 pwr_off_req in reset", 32'(pwr_off_req), 0);
    chk("R1 sys_rst_req in reset", 32'(sys_rst_req), 0);
    rst_n = 1'b1;
    rd(3'd0, 2'd0, 0, "R1 cfg after reset");
    rd(3'd6, 2'd0, 0, "R1 aux2 after reset");

    // R9 / R10: system control request
    wr(3'd4, 2'd0, 32'h1);
    chk("R9 reset request pulse", 32'(sys_rst_req), 1);
    @(negedge clk);
    chk("R9 reset request one cycle", 32'(sys_rst_req), 0);
    rd(3'd4, 2'd0, 32'h2, "R10 sysctrl status");
    wr(3'd4, 2'd0, 32'hFFFF_FFFE);
    chk("R9 bit0 clear no request", 32'(sys_rst_req), 0);
    rd(3'd4, 2'd0, 32'h2, "R9 bit0 clear no change");
    wr(3'd4, 2'd2, 32'h1);
    chk("R9 nonzero offset no request", 32'(sys_rst_req), 0);
    for (int o = 1; o < 4; o++) rd(3'd4, 2'(o), 0, "R10 sysctrl other offset");

    // R2: block reset keeps diag and sysctrl, clears the others
    wr(3'd1, 2'd0, 32'hA5);
    wr(3'd0, 2'd0, 32'hF7);
    wr(3'd2, 2'd0, 32'h3C);
    wr(3'd5, 2'd0, 32'hFD);
    wr(3'd6, 2'd0, 32'h1);
    chk("R6 power-off pulse", 32'(pwr_off_req), 1);
    @(negedge clk);
    chk("R6 power-off one cycle", 32'(pwr_off_req), 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, 2'd0, 0, "R1 cfg cleared");
    rd(3'd2, 2'd0, 0, "R1 modem cleared");
    rd(3'd5, 2'd0, 0, "R1 aux1 cleared");
    rd(3'd6, 2'd0, 0, "R1 aux2 cleared");
    rd(3'd1, 2'd0, 32'hA5, "R2 diag kept");
    rd(3'd4, 2'd0, 32'h2, "R2 sysctrl kept");

    // R3: plain byte storage sweeps
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 256; v++) begin
        wr(3'(s), 2'(v % 4), 32'(v) | 32'hABCD_0000);
        rd(3'(s), 2'(3 - v % 4), 32'(v), "R3 byte readback");
      end
    end
    rd(3'd7, 2'd0, 0, "R3 unused select");
    @(negedge clk);
    bus_sel = 3'd0; bus_rd = 1'b0; #1;
    chk("R3 idle read zero", bus_rdata, 0);

    // R4: aux1 sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd5, 2'd0, 32'(v));
      chk("R4 tc pulse", 32'(fdc_tc), 32'((v >> 1) & 1));
      rd(3'd5, 2'd0, 32'(v & 8'hFD), "R4 aux1 stored");
      chk("R4 tc one cycle", 32'(fdc_tc), 0);
    end

    // R5 / R6: aux2 sweep with the enable off
    wr(3'd0, 2'd0, 32'h0);
    for (int v = 0; v < 256; v++) begin
      wr(3'd6, 2'd0, 32'(v));
      chk("R6 power-off follows bit0", 32'(pwr_off_req), 32'(v & 1));
      rd(3'd6, 2'd0, aux2_exp(0, v[0]), "R5 aux2 keeps bit0 only");
    end
    wr(3'd6, 2'd0, 32'h0);

    // R7 / R8: power-fail flag and interrupt
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    rd(3'd6, 2'd0, aux2_exp(0, 0), "R7 no flag with enable off");
    chk("R8 irq low enable off", 32'(irq), 0);
    @(negedge clk); pwr_fail = 1'b0;
    wr(3'd0, 2'd0, 32'h08);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R8 irq lags flag", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq raised", 32'(irq), 1);
    rd(3'd6, 2'd0, aux2_exp(1, 0), "R7 flag set");
    wr(3'd6, 2'd0, 32'h1);
    rd(3'd6, 2'd0, aux2_exp(1, 1), "R5 flag merged");
    wr(3'd6, 2'd0, 32'h0);
    wr(3'd0, 2'd0, 32'h00);
    chk("R8 irq still high one cycle", 32'(irq), 1);
    @(negedge clk);
    chk("R8 irq masked", 32'(irq), 0);
    rd(3'd6, 2'd0, aux2_exp(1, 0), "R7 flag kept while masked");
    wr(3'd0, 2'd0, 32'h08);
    @(negedge clk);
    chk("R8 irq unmasked", 32'(irq), 1);
    wr(3'd6, 2'd0, 32'h2);
    rd(3'd6, 2'd0, aux2_exp(0, 0), "R5 clear write");
    chk("R8 irq after clear", 32'(irq), 0);
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk);
    rd(3'd6, 2'd0, aux2_exp(0, 0), "R7 falling input keeps clear");
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    rd(3'd6, 2'd0, aux2_exp(1, 0), "R7 set again");
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk);
    rd(3'd6, 2'd0, aux2_exp(0, 0), "R7 falling input clears");

    // R12: clear write and rising input on one edge
    @(negedge clk);
    pwr_fail = 1'b1; bus_wr = 1'b1; bus_sel = 3'd6; bus_off = '0; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd(3'd6, 2'd0, aux2_exp(1, 0), "R12 input change wins");

    // R11: LED register
    for (int v = 0; v < 64; v++) begin
      logic [15:0] a;
      a = 16'((v * 1031 + 17) & 16'hFFFF);
      wr(3'd3, 2'd0, {16'hDEAD, a});
      rd(3'd3, 2'd0, 32'(a), "R11 led readback");
      wr(3'd3, 2'(1 + v % 3), 32'(~a));
      rd(3'd3, 2'd0, 32'(a), "R11 led offset write ignored");
      rd(3'd3, 2'(1 + v % 3), 0, "R11 led offset read zero");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule